// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock

This block keeps wall-clock time and date in packed BCD: seconds, minutes, hours (24-hour), day of month, month and a four-digit year held as two bytes. It counts pulses of a 32.768 kHz reference clock enable and divides them down to a one-second tick. On each tick the time advances by one second. The carries ripple through the calendar, which knows each month's length and the Gregorian leap-year rule.

A host reaches the block through a plain byte-wide register bus. A combinational read port returns the selected register. A write strobe loads a register at the next clock edge. A control register holds two bits. The run bit gates the timebase. The hold bit freezes the copy the host reads, so a multi-byte read cannot tear across a carry, while the clock keeps counting underneath. Any write to a time register takes effect at once and restarts the sub-second divider, so the first full second starts from the write.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the registers read: seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01, year-low 0x00, year-high 0x20, control 0x00. The select codes are 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year-low, 6 year-high, 7 control. Control bit 0 is run and bit 1 is hold. Each byte is BCD with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R2: While run is 1, the seconds advance by exactly one on every PRESCALE-th cycle in which `ref_pulse` is high (PRESCALE defaults to 32768). Cycles without a pulse have no effect.
- R3: While run is 0, reference pulses do not advance the time.
- R4: Seconds and minutes wrap from 0x59 to 0x00 and carry one into the next field. Hours wrap from 0x23 to 0x00 and carry into the day.
- R5: The day wraps to 0x01 after 0x30 in months 04, 06, 09 and 11, and after 0x31 in the other months except February. A wrap carries into the month. The month wraps from 0x12 to 0x01 and carries into the year.
- R6: February ends at 0x29 in leap years and at 0x28 otherwise. A year is a leap year when it is divisible by 4 and not by 100, or when it is divisible by 400.
- R7: The year counts as four BCD digits. Year-low wraps from 0x99 to 0x00 and increments year-high. Year 9999 rolls over to 0000.
- R8: A write to a time register (selects 0 to 6) shows in that register on the cycle after the write strobe. The write also restarts the divider, so the next second needs a full PRESCALE pulses.
- R9: While hold is 1, reads of the time registers return the values captured when hold was set, and the internal time keeps counting. Clearing hold shows the live time again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pulse | input | 1 | One-cycle enable per 32.768 kHz reference period |
| reg_sel | input | 3 | Register select for read and write |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read of the selected register |

## Verification
The bench drives the calendar to the edges where carries chain: 23:59:59 at a month end, 31 December of year 9999, and the end of February in 2000, 2023, 2024 and 2100. A wrong month-length or leap-year decode shows up as a date like 30 February or a missed 29 February. A century rule that is wrong in either direction is caught by the 2100 and 2000 cases. It counts reference pulses around a mid-second write. A divider that is not restarted would tick early, and one that counts without pulses or with run cleared would advance the seconds when it should not. The hold test reads a frozen value after a tick, then releases hold and expects the advanced second. A snapshot that follows the live time, or a counter that stops during hold, would both fail.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_SEC  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_MIN  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_HOUR = 3'd2;
  localparam logic [SEL_W-1:0] SEL_DAY  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_MON  = 3'd4;
  localparam logic [SEL_W-1:0] SEL_YLO  = 3'd5;
  localparam logic [SEL_W-1:0] SEL_YHI  = 3'd6;
  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd7;

  typedef struct packed {
    logic [7:0] yhi;
    logic [7:0] ylo;
    logic [7:0] mon;
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam rtc_time_t TIME_RESET = '{yhi: 8'h20, ylo: 8'h00, mon: 8'h01,
                                       day: 8'h01, hour: 8'h00, min: 8'h00,
                                       sec: 8'h00};

  // Add one to a two-digit BCD value; the caller handles the wrap.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  // Gregorian rule: lower pair 00 defers to the century pair.
  function automatic logic is_leap(input logic [7:0] ylo, input logic [7:0] yhi);
    logic [6:0] b;
    b = (ylo == 8'h00) ? bcd_to_bin(yhi) : bcd_to_bin(ylo);
    return (b[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                input logic [7:0] ylo,
                                                input logic [7:0] yhi);
    case (mon)
      8'h02:                      return is_leap(ylo, yhi) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] time_byte(input rtc_time_t t,
                                           input logic [SEL_W-1:0] sel);
    case (sel)
      SEL_SEC:  return t.sec;
      SEL_MIN:  return t.min;
      SEL_HOUR: return t.hour;
      SEL_DAY:  return t.day;
      SEL_MON:  return t.mon;
      SEL_YLO:  return t.ylo;
      SEL_YHI:  return t.yhi;
      default:  return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/bcd_rtc_prescaler.sv
module bcd_rtc_prescaler #(
  parameter int PRESCALE = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pulse,
  input  logic run,
  input  logic restart,
  output logic sec_tick,
  output logic at_zero
);
  localparam int CW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] cnt_q;
  logic          count_en;

  assign count_en = ref_pulse && run && !restart;
  assign sec_tick = count_en && (cnt_q == LAST);
  assign at_zero  = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt_q <= '0;
    else if (sec_tick)     cnt_q <= '0;
    else if (count_en)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bcd_rtc_calendar.sv
module bcd_rtc_calendar
  import bcd_rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [7:0]       wr_data,
  output rtc_time_t        now
);
  rtc_time_t now_q, nxt;
  logic c_min, c_hour, c_day, c_mon, c_year;

  always_comb begin
    nxt    = now_q;
    c_min  = 1'b0;
    c_hour = 1'b0;
    c_day  = 1'b0;
    c_mon  = 1'b0;
    c_year = 1'b0;
    if (sec_tick) begin
      c_min   = (now_q.sec == 8'h59);
      nxt.sec = c_min ? 8'h00 : bcd_inc(now_q.sec);
      if (c_min) begin
        c_hour  = (now_q.min == 8'h59);
        nxt.min = c_hour ? 8'h00 : bcd_inc(now_q.min);
      end
      if (c_hour) begin
        c_day    = (now_q.hour == 8'h23);
        nxt.hour = c_day ? 8'h00 : bcd_inc(now_q.hour);
      end
      if (c_day) begin
        c_mon   = (now_q.day == month_last_day(now_q.mon, now_q.ylo, now_q.yhi));
        nxt.day = c_mon ? 8'h01 : bcd_inc(now_q.day);
      end
      if (c_mon) begin
        c_year  = (now_q.mon == 8'h12);
        nxt.mon = c_year ? 8'h01 : bcd_inc(now_q.mon);
      end
      if (c_year) begin
        nxt.ylo = (now_q.ylo == 8'h99) ? 8'h00 : bcd_inc(now_q.ylo);
        if (now_q.ylo == 8'h99)
          nxt.yhi = (now_q.yhi == 8'h99) ? 8'h00 : bcd_inc(now_q.yhi);
      end
    end
    if (wr_en) begin
      case (wr_sel)
        SEL_SEC:  nxt.sec  = wr_data;
        SEL_MIN:  nxt.min  = wr_data;
        SEL_HOUR: nxt.hour = wr_data;
        SEL_DAY:  nxt.day  = wr_data;
        SEL_MON:  nxt.mon  = wr_data;
        SEL_YLO:  nxt.ylo  = wr_data;
        SEL_YHI:  nxt.yhi  = wr_data;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) now_q <= TIME_RESET;
    else        now_q <= nxt;
  end

  assign now = now_q;
endmodule

// File: rtl/bcd_rtc_snapshot.sv
module bcd_rtc_snapshot
  import bcd_rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hold,
  input  rtc_time_t live,
  output rtc_time_t shadow,
  output rtc_time_t view
);
  rtc_time_t shadow_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     shadow_q <= TIME_RESET;
    else if (!hold) shadow_q <= live;
  end

  assign shadow = shadow_q;
  assign view   = hold ? shadow_q : live;
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import bcd_rtc_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_pulse,
  input  logic [2:0] reg_sel,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data
);
  logic      run_q, hold_q;
  logic      time_wr, ctrl_wr;
  logic      sec_tick, presc_at_zero;
  rtc_time_t live, shadow, view;

  assign ctrl_wr = wr_en && (reg_sel == SEL_CTRL);
  assign time_wr = wr_en && (reg_sel != SEL_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      hold_q <= 1'b0;
    end else if (ctrl_wr) begin
      run_q  <= wr_data[0];
      hold_q <= wr_data[1];
    end
  end

  bcd_rtc_prescaler #(.PRESCALE(PRESCALE)) presc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_pulse(ref_pulse),
    .run      (run_q),
    .restart  (time_wr),
    .sec_tick (sec_tick),
    .at_zero  (presc_at_zero)
  );

  bcd_rtc_calendar cal_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sec_tick(sec_tick),
    .wr_en   (time_wr),
    .wr_sel  (reg_sel),
    .wr_data (wr_data),
    .now     (live)
  );

  bcd_rtc_snapshot snap_i (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (hold_q),
    .live  (live),
    .shadow(shadow),
    .view  (view)
  );

  always_comb begin
    if (reg_sel == SEL_CTRL) rd_data = {6'd0, hold_q, run_q};
    else                     rd_data = time_byte(view, reg_sel);
  end
endmodule

// File: rtl/bcd_rtc_checker.sv
module bcd_rtc_checker
  import bcd_rtc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ref_pulse,
  input logic       wr_en,
  input logic [2:0] reg_sel,
  input logic [7:0] wr_data,
  input logic       run,
  input logic       hold,
  input logic       sec_tick,
  input logic       presc_at_zero,
  input rtc_time_t  live,
  input rtc_time_t  shadow
);
  logic time_wr;
  assign time_wr = wr_en && (reg_sel != SEL_CTRL);

  // R2: without a reference pulse the seconds stay put
  a_r2_no_pulse_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_pulse && !time_wr) |=> $stable(live.sec));

  // R3: a stopped oscillator freezes the time
  a_r3_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !time_wr) |=> $stable(live));

  // R4: seconds wrap to zero
  a_r4_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && live.sec == 8'h59) |=> (live.sec == 8'h00));

  // R4: minutes move only on a seconds wrap
  a_r4_min_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (!time_wr && !(sec_tick && live.sec == 8'h59)) |=> $stable(live.min));

  // R8: a seconds write lands on the next cycle
  a_r8_write_sec: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == SEL_SEC) |=> (live.sec == $past(wr_data)));

  // R8: a time write restarts the divider
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr |=> presc_at_zero);

  // R9: the snapshot is frozen while hold is set
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(shadow));
endmodule

bind bcd_rtc bcd_rtc_checker chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .ref_pulse    (ref_pulse),
  .wr_en        (wr_en),
  .reg_sel      (reg_sel),
  .wr_data      (wr_data),
  .run          (run_q),
  .hold         (hold_q),
  .sec_tick     (sec_tick),
  .presc_at_zero(presc_at_zero),
  .live         (live),
  .shadow       (shadow)
);

// File: tb/bcd_rtc_tb_top.sv
`timescale 1ns/1ps
module bcd_rtc_tb_top;
  localparam int PS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_pulse = 1'b0;
  logic [2:0] reg_sel = 3'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  bcd_rtc #(.PRESCALE(PS)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .reg_sel(reg_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      errors = errors + 1;
      $display("FAIL watchdog: got %0d cycles exp below 50000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
    checks = checks + 1;
    if (got !== exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: got %02h exp %02h", req, what, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] v);
    @(negedge clk);
    reg_sel = s;
    #1 v = rd_data;
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_pulse = 1'b1;
      @(negedge clk); ref_pulse = 1'b0;
    end
  endtask

  task automatic set_time(input logic [7:0] yh, input logic [7:0] yl,
                          input logic [7:0] mo, input logic [7:0] d,
                          input logic [7:0] h, input logic [7:0] mi,
                          input logic [7:0] s);
    wr(3'd6, yh); wr(3'd5, yl); wr(3'd4, mo); wr(3'd3, d);
    wr(3'd2, h);  wr(3'd1, mi); wr(3'd0, s);
  endtask

  task automatic expect_date(input string req, input logic [7:0] yh,
                             input logic [7:0] yl, input logic [7:0] mo,
                             input logic [7:0] d);
    logic [7:0] v;
    rd(3'd6, v); check(req, "year-high", v, yh);
    rd(3'd5, v); check(req, "year-low", v, yl);
    rd(3'd4, v); check(req, "month", v, mo);
    rd(3'd3, v); check(req, "day", v, d);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    logic [7:0] exp [8] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h20, 8'h00};
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      check("R1", $sformatf("reset reg %0d", i), v, exp[i]);
    end
  endtask

  task automatic t_stopped();
    logic [7:0] v;
    pulses(3 * PS);
    rd(3'd0, v); check("R3", "seconds with run clear", v, 8'h00);
  endtask

  task automatic t_prescale();
    logic [7:0] v;
    wr(3'd7, 8'h01);
    rd(3'd7, v); check("R1", "control run bit", v, 8'h01);
    repeat (10) @(negedge clk);
    pulses(PS - 1);
    rd(3'd0, v); check("R2", "one pulse short of a second", v, 8'h00);
    pulses(1);
    rd(3'd0, v); check("R2", "after a full second", v, 8'h01);
    pulses(2 * PS);
    rd(3'd0, v); check("R2", "after two more seconds", v, 8'h03);
  endtask

  task automatic t_restart();
    logic [7:0] v;
    pulses(2);
    wr(3'd0, 8'h30);
    rd(3'd0, v); check("R8", "written seconds", v, 8'h30);
    pulses(PS - 1);
    rd(3'd0, v); check("R8", "divider restarted, no early tick", v, 8'h30);
    pulses(1);
    rd(3'd0, v); check("R8", "tick after full count", v, 8'h31);
  endtask

  task automatic t_rollover();
    logic [7:0] v;
    set_time(8'h20, 8'h23, 8'h03, 8'h15, 8'h23, 8'h59, 8'h59);
    pulses(PS);
    rd(3'd0, v); check("R4", "seconds wrap", v, 8'h00);
    rd(3'd1, v); check("R4", "minutes wrap", v, 8'h00);
    rd(3'd2, v); check("R4", "hours wrap", v, 8'h00);
    expect_date("R4", 8'h20, 8'h23, 8'h03, 8'h16);
    set_time(8'h20, 8'h23, 8'h03, 8'h15, 8'h10, 8'h09, 8'h59);
    pulses(PS);
    rd(3'd1, v); check("R4", "minute units carry", v, 8'h10);
    rd(3'd2, v); check("R4", "hour unchanged", v, 8'h10);
  endtask

  task automatic t_months();
    set_time(8'h20, 8'h23, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
    pulses(PS);
    expect_date("R5", 8'h20, 8'h23, 8'h05, 8'h01);
    set_time(8'h20, 8'h23, 8'h05, 8'h30, 8'h23, 8'h59, 8'h59);
    pulses(PS);
    expect_date("R5", 8'h20, 8'h23, 8'h05, 8'h31);
    set_time(8'h20, 8'h23, 8'h11, 8'h30, 8'h23, 8'h59, 8'h59);
    pulses(PS);
    expect_date("R5", 8'h20, 8'h23, 8'h12, 8'h01);
    set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    pulses(PS);
    expect_date("R7", 8'h21, 8'h00, 8'h01, 8'h01);
  endtask

  task automatic t_leap();
    set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    pulses(PS);
    expect_date("R6", 8'h20, 8'h24, 8'h02, 8'h29);
    pulses(PS * 86400 / 86400);
    set_time(8'h20, 8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59);
    pulses(PS);
    expect_date("R6", 8'h20, 8'h24, 8'h03, 8'h01);
    set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    pulses(PS);
    expect_date("R6", 8'h20, 8'h23, 8'h03, 8'h01);
    set_time(8'h21, 8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    pulses(PS);
    expect_date("R6", 8'h21, 8'h00, 8'h03, 8'h01);
    set_time(8'h20, 8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    pulses(PS);
    expect_date("R6", 8'h20, 8'h00, 8'h02, 8'h29);
  endtask

  task automatic t_year_wrap();
    logic [7:0] v;
    set_time(8'h99, 8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    pulses(PS);
    expect_date("R7", 8'h00, 8'h00, 8'h01, 8'h01);
    rd(3'd2, v); check("R7", "hours after 9999", v, 8'h00);
  endtask

  task automatic t_hold();
    logic [7:0] v;
    set_time(8'h20, 8'h30, 8'h06, 8'h10, 8'h08, 8'h20, 8'h10);
    wr(3'd7, 8'h03);
    rd(3'd7, v); check("R9", "control run+hold", v, 8'h03);
    pulses(PS);
    rd(3'd0, v); check("R9", "seconds frozen under hold", v, 8'h10);
    pulses(PS);
    rd(3'd0, v); check("R9", "still frozen", v, 8'h10);
    wr(3'd7, 8'h01);
    rd(3'd0, v); check("R9", "live seconds after release", v, 8'h12);
    rd(3'd1, v); check("R9", "live minutes after release", v, 8'h20);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_stopped();
    t_prescale();
    t_restart();
    t_rollover();
    t_months();
    t_leap();
    t_year_wrap();
    t_hold();
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule